// File: doc/BRIEF.md
# Tagged Sequential Block Prefetcher

This controller sits beside a cache and watches its access events. Each event carries a block address, a flag saying whether the access missed, and the current value of the block's prefetch mark. The mark is a single bit per cache block. From these events the controller decides when to look ahead. It then emits requests for the blocks that follow the accessed one, one address per cycle, over a valid/ready handshake. When a marked block is referenced for the first time, it also emits a command to clear that block's mark. The cache is assumed to set the mark itself whenever it fills a block in answer to one of these requests.

Two trigger policies are available through a mode input. In miss-only mode, only a demand miss starts a lookahead. In marked mode, a lookahead is also started by the first hit on a block that a prefetch brought in. In both modes the controller counts how many requests it has issued and how many marked blocks were later used. At the end of each window of issued requests, it raises or lowers the lookahead depth from the ratio of the two counts.

Top module: `seq_block_prefetcher`

## Requirements
- R1: After reset, `pf_valid` and `tag_clr_valid` are 0 and `pf_depth` equals 1.
- R2: With `mode` = 0 (miss-only), an access starts a lookahead only when `acc_miss` = 1. A hit is ignored whatever `acc_tag` holds.
- R3: With `mode` = 1 (marked), an access starts a lookahead when `acc_miss` = 1, or when `acc_miss` = 0 and `acc_tag` = 1. A hit with `acc_tag` = 0 starts none.
- R4: A lookahead started by an access to block b in one cycle raises `pf_valid` in the next cycle with `pf_addr` = b+1. Each accepted request then presents the next block, through b+K, where K is `pf_depth` sampled at the start of the lookahead. After the K-th acceptance `pf_valid` falls.
- R5: While `pf_valid` = 1 and `pf_ready` = 0 and no new lookahead starts, `pf_valid` stays 1 and `pf_addr` stays unchanged.
- R6: A lookahead that starts while requests are still pending discards those requests and restarts from the new block.
- R7: Request addresses wrap modulo 2^ADDR_W, so block all-ones is followed by block 0.
- R8: A hit on a marked block (`acc_miss` = 0, `acc_tag` = 1) in either mode gives `tag_clr_valid` = 1 in the next cycle, with `tag_clr_addr` equal to that block. No other access clears a mark.
- R9: A window closes on the cycle of the EVAL_PERIOD-th accepted request. The useful count is the number of marked hits in the window, that cycle included, saturating at EVAL_PERIOD. If 4 × useful > 3 × EVAL_PERIOD, `pf_depth` rises by one in the next cycle.
- R10: If 4 × useful < EVAL_PERIOD when a window closes, `pf_depth` falls by one in the next cycle.
- R11: `pf_depth` never leaves the range 1 to KMAX. A rise at KMAX and a fall at 1 leave it unchanged.
- R12: `pf_depth` changes only when a window closes, and then by exactly one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 1 | Trigger policy: 0 miss-only, 1 marked |
| acc_valid | input | 1 | A cache access event is present |
| acc_addr | input | ADDR_W | Block address of the access |
| acc_miss | input | 1 | The access was a demand miss |
| acc_tag | input | 1 | Prefetch mark of the accessed block |
| pf_valid | output | 1 | A prefetch request is offered |
| pf_addr | output | ADDR_W | Block address of the offered request |
| pf_ready | input | 1 | The memory side accepts the offered request |
| tag_clr_valid | output | 1 | Clear the prefetch mark of a block |
| tag_clr_addr | output | ADDR_W | Block whose mark is cleared |
| pf_depth | output | $clog2(KMAX+1) | Current lookahead depth K |

## Verification
The hardest state to reach from the ports is a closed usefulness window whose useful count lies on a chosen side of a threshold. Reaching it takes a full window of accepted requests, with marked hits placed in the same cycles as the acceptances. The bench shortens the window through a parameter. It then drives repeating miss/hit/accept patterns that force each case: a rise, a fall, a hold at the floor, and saturation at the ceiling. Each case is reached after a known number of acceptances. Lookahead replacement is reached by holding `pf_ready` low so that requests remain pending when a second miss arrives.

// File: rtl/sbp_pkg.sv
package sbp_pkg;

   typedef enum logic {
      TRIG_ON_MISS = 1'b0,
      TRIG_MARKED  = 1'b1
   } trig_mode_e;

   // Threshold helpers for the usefulness ratio, in units of quarters.
   function automatic logic ratio_high(input int unsigned useful, input int unsigned period);
      return (useful * 4) > (period * 3);
   endfunction

   function automatic logic ratio_low(input int unsigned useful, input int unsigned period);
      return (useful * 4) < period;
   endfunction

endpackage

// File: rtl/sbp_trigger.sv
module sbp_trigger
   import sbp_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_miss,
   input  logic              acc_tag,
   output logic              trig,
   output logic              useful_hit,
   output logic              tag_clr_valid,
   output logic [ADDR_W-1:0] tag_clr_addr
);

   trig_mode_e mode_q;
   logic       marked_hit;

   assign mode_q     = trig_mode_e'(mode);
   assign marked_hit = acc_valid && !acc_miss && acc_tag;
   assign useful_hit = marked_hit;

   always_comb begin
      unique case (mode_q)
         TRIG_ON_MISS: trig = acc_valid && acc_miss;
         TRIG_MARKED:  trig = (acc_valid && acc_miss) || marked_hit;
         default:      trig = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tag_clr_valid <= 1'b0;
         tag_clr_addr  <= '0;
      end else begin
         tag_clr_valid <= marked_hit;
         if (marked_hit) begin
            tag_clr_addr <= acc_addr;
         end
      end
   end

endmodule

// File: rtl/sbp_req_queue.sv
module sbp_req_queue #(
   parameter int ADDR_W = 32,
   parameter int KMAX   = 8,
   localparam int KW    = $clog2(KMAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig,
   input  logic [ADDR_W-1:0] trig_addr,
   input  logic [KW-1:0]     depth,
   input  logic              pf_ready,
   output logic              pf_valid,
   output logic [ADDR_W-1:0] pf_addr,
   output logic              fire
);

   logic [ADDR_W-1:0] base_q;
   logic [KW-1:0]     off_q;
   logic [KW-1:0]     left_q;

   assign pf_valid = (left_q != '0);
   assign fire     = pf_valid && pf_ready;
   assign pf_addr  = base_q + ADDR_W'(off_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         off_q  <= KW'(1);
         left_q <= '0;
      end else if (trig) begin
         base_q <= trig_addr;
         off_q  <= KW'(1);
         left_q <= depth;
      end else if (fire) begin
         off_q  <= off_q + KW'(1);
         left_q <= left_q - KW'(1);
      end
   end

endmodule

// File: rtl/sbp_depth_ctl.sv
module sbp_depth_ctl
   import sbp_pkg::*;
#(
   parameter int KMAX        = 8,
   parameter int K_INIT      = 1,
   parameter int EVAL_PERIOD = 256,
   parameter bit ADAPT_EN    = 1'b1,
   localparam int KW         = $clog2(KMAX + 1),
   localparam int CW         = $clog2(EVAL_PERIOD + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fire,
   input  logic          useful_hit,
   output logic [KW-1:0] depth
);

   generate
      if (ADAPT_EN) begin : g_adapt
         logic [CW-1:0] issued_q;
         logic [CW-1:0] useful_q;
         logic [CW-1:0] useful_nx;
         logic          win_end;
         logic          go_up;
         logic          go_down;
         logic [KW-1:0] depth_q;

         assign useful_nx = (useful_hit && (useful_q != CW'(EVAL_PERIOD)))
                            ? useful_q + CW'(1) : useful_q;
         assign win_end   = fire && (issued_q == CW'(EVAL_PERIOD - 1));
         assign go_up     = ratio_high(int'(useful_nx), EVAL_PERIOD);
         assign go_down   = ratio_low(int'(useful_nx), EVAL_PERIOD);
         assign depth     = depth_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               issued_q <= '0;
               useful_q <= '0;
               depth_q  <= KW'(K_INIT);
            end else if (win_end) begin
               issued_q <= '0;
               useful_q <= '0;
               if (go_up && (depth_q != KW'(KMAX))) begin
                  depth_q <= depth_q + KW'(1);
               end else if (go_down && (depth_q != KW'(1))) begin
                  depth_q <= depth_q - KW'(1);
               end
            end else begin
               useful_q <= useful_nx;
               if (fire) begin
                  issued_q <= issued_q + CW'(1);
               end
            end
         end
      end else begin : g_fixed
         logic unused_in;
         assign unused_in = fire ^ useful_hit;
         assign depth     = KW'(K_INIT);
      end
   endgenerate

endmodule

// File: rtl/seq_block_prefetcher.sv
module seq_block_prefetcher #(
   parameter int ADDR_W      = 32,
   parameter int KMAX        = 8,
   parameter int K_INIT      = 1,
   parameter int EVAL_PERIOD = 256,
   parameter bit ADAPT_EN    = 1'b1,
   localparam int KW         = $clog2(KMAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_miss,
   input  logic              acc_tag,
   output logic              pf_valid,
   output logic [ADDR_W-1:0] pf_addr,
   input  logic              pf_ready,
   output logic              tag_clr_valid,
   output logic [ADDR_W-1:0] tag_clr_addr,
   output logic [KW-1:0]     pf_depth
);

   generate
      if (ADDR_W < 2) begin : g_bad_addr_w
         $error("ADDR_W must be at least 2");
      end
      if (KMAX < 1) begin : g_bad_kmax
         $error("KMAX must be at least 1");
      end
      if ((K_INIT < 1) || (K_INIT > KMAX)) begin : g_bad_kinit
         $error("K_INIT must lie in 1..KMAX");
      end
      if (EVAL_PERIOD < 4) begin : g_bad_period
         $error("EVAL_PERIOD must be at least 4");
      end
   endgenerate

   logic trig;
   logic useful_hit;
   logic fire;

   sbp_trigger #(
      .ADDR_W (ADDR_W)
   ) u_trigger (
      .clk           (clk),
      .rst_n         (rst_n),
      .mode          (mode),
      .acc_valid     (acc_valid),
      .acc_addr      (acc_addr),
      .acc_miss      (acc_miss),
      .acc_tag       (acc_tag),
      .trig          (trig),
      .useful_hit    (useful_hit),
      .tag_clr_valid (tag_clr_valid),
      .tag_clr_addr  (tag_clr_addr)
   );

   sbp_req_queue #(
      .ADDR_W (ADDR_W),
      .KMAX   (KMAX)
   ) u_queue (
      .clk       (clk),
      .rst_n     (rst_n),
      .trig      (trig),
      .trig_addr (acc_addr),
      .depth     (pf_depth),
      .pf_ready  (pf_ready),
      .pf_valid  (pf_valid),
      .pf_addr   (pf_addr),
      .fire      (fire)
   );

   sbp_depth_ctl #(
      .KMAX        (KMAX),
      .K_INIT      (K_INIT),
      .EVAL_PERIOD (EVAL_PERIOD),
      .ADAPT_EN    (ADAPT_EN)
   ) u_depth (
      .clk        (clk),
      .rst_n      (rst_n),
      .fire       (fire),
      .useful_hit (useful_hit),
      .depth      (pf_depth)
   );

endmodule

// File: rtl/seq_block_prefetcher_chk.sv
module seq_block_prefetcher_chk #(
   parameter int ADDR_W = 32,
   parameter int KMAX   = 8,
   localparam int KW    = $clog2(KMAX + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mode,
   input logic              acc_valid,
   input logic [ADDR_W-1:0] acc_addr,
   input logic              acc_miss,
   input logic              acc_tag,
   input logic              pf_valid,
   input logic [ADDR_W-1:0] pf_addr,
   input logic              pf_ready,
   input logic              tag_clr_valid,
   input logic [ADDR_W-1:0] tag_clr_addr,
   input logic [KW-1:0]     pf_depth
);

   logic start_seen;
   assign start_seen = acc_valid && (acc_miss || (mode && acc_tag));

   AST_DEPTH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (pf_depth >= KW'(1)) && (pf_depth <= KW'(KMAX))); // R11

   AST_MISS_NEXT_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_miss) |=> (pf_valid && (pf_addr == $past(acc_addr) + ADDR_W'(1)))); // R4

   AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (pf_valid && !pf_ready && !start_seen) |=> (pf_valid && $stable(pf_addr))); // R5

   AST_IDLE_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!pf_valid && !acc_valid) |=> !pf_valid); // R2

   AST_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      tag_clr_valid |-> ($past(acc_valid && !acc_miss && acc_tag)
                         && (tag_clr_addr == $past(acc_addr)))); // R8

   AST_DEPTH_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pf_depth) |-> ((pf_depth == $past(pf_depth) + KW'(1))
                              || (pf_depth == $past(pf_depth) - KW'(1)))); // R12

   AST_DEPTH_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pf_depth) |-> $past(pf_valid && pf_ready)); // R9

endmodule

bind seq_block_prefetcher seq_block_prefetcher_chk #(
   .ADDR_W (ADDR_W),
   .KMAX   (KMAX)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .mode          (mode),
   .acc_valid     (acc_valid),
   .acc_addr      (acc_addr),
   .acc_miss      (acc_miss),
   .acc_tag       (acc_tag),
   .pf_valid      (pf_valid),
   .pf_addr       (pf_addr),
   .pf_ready      (pf_ready),
   .tag_clr_valid (tag_clr_valid),
   .tag_clr_addr  (tag_clr_addr),
   .pf_depth      (pf_depth)
);

// File: tb/seq_block_prefetcher_bench.sv
`timescale 1ns/1ps
module seq_block_prefetcher_bench;

   localparam int AW     = 16;
   localparam int KMAX_T = 4;
   localparam int EVAL_T = 16;
   localparam int KW_T   = $clog2(KMAX_T + 1);
   localparam int NVEC   = 8;

   // vector: mode, miss, tag, addr[16], exp_valid, exp_addr[16], exp_clr
   localparam logic [36:0] VEC [NVEC] = '{
      {1'b0, 1'b0, 1'b0, 16'h0100, 1'b0, 16'h0000, 1'b0},  // R2 hit ignored
      {1'b0, 1'b1, 1'b0, 16'h0100, 1'b1, 16'h0101, 1'b0},  // R2 miss starts
      {1'b0, 1'b0, 1'b1, 16'h0200, 1'b0, 16'h0000, 1'b1},  // R2 marked hit ignored, R8 clear
      {1'b1, 1'b0, 1'b1, 16'h0200, 1'b1, 16'h0201, 1'b1},  // R3 marked hit starts
      {1'b1, 1'b1, 1'b0, 16'h0300, 1'b1, 16'h0301, 1'b0},  // R3 miss starts
      {1'b1, 1'b0, 1'b0, 16'h0300, 1'b0, 16'h0000, 1'b0},  // R3 plain hit ignored
      {1'b1, 1'b1, 1'b0, 16'hFFFF, 1'b1, 16'h0000, 1'b0},  // R7 wrap
      {1'b0, 1'b1, 1'b1, 16'h0400, 1'b1, 16'h0401, 1'b0}   // R8 miss never clears
   };

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            mode = 1'b0;
   logic            acc_valid = 1'b0;
   logic [AW-1:0]   acc_addr = '0;
   logic            acc_miss = 1'b0;
   logic            acc_tag = 1'b0;
   logic            pf_valid;
   logic [AW-1:0]   pf_addr;
   logic            pf_ready = 1'b0;
   logic            tag_clr_valid;
   logic [AW-1:0]   tag_clr_addr;
   logic [KW_T-1:0] pf_depth;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   seq_block_prefetcher #(
      .ADDR_W      (AW),
      .KMAX        (KMAX_T),
      .K_INIT      (1),
      .EVAL_PERIOD (EVAL_T),
      .ADAPT_EN    (1'b1)
   ) u_seq_block_prefetcher (
      .clk           (clk),
      .rst_n         (rst_n),
      .mode          (mode),
      .acc_valid     (acc_valid),
      .acc_addr      (acc_addr),
      .acc_miss      (acc_miss),
      .acc_tag       (acc_tag),
      .pf_valid      (pf_valid),
      .pf_addr       (pf_addr),
      .pf_ready      (pf_ready),
      .tag_clr_valid (tag_clr_valid),
      .tag_clr_addr  (tag_clr_addr),
      .pf_depth      (pf_depth)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; acc_valid = 1'b0; pf_ready = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // Presents one access for one cycle; returns at the negedge after the capturing edge.
   task automatic do_acc(input logic miss, input logic tag, input logic [AW-1:0] a);
      acc_valid = 1'b1; acc_miss = miss; acc_tag = tag; acc_addr = a;
      @(negedge clk);
      acc_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      do_reset();
      check("R1 pf_valid", 32'(pf_valid), 0);
      check("R1 tag_clr_valid", 32'(tag_clr_valid), 0);
      check("R1 depth", 32'(pf_depth), 1);

      // Table walk: each vector from a fresh reset, requests held back.
      for (int v = 0; v < NVEC; v++) begin
         do_reset();
         mode = VEC[v][36];
         do_acc(VEC[v][35], VEC[v][34], VEC[v][33:18]);
         check($sformatf("R4 vec%0d valid", v), 32'(pf_valid), 32'(VEC[v][17]));
         if (VEC[v][17]) check($sformatf("R4 vec%0d addr", v), 32'(pf_addr), 32'(VEC[v][16:1]));
         check($sformatf("R8 vec%0d clr", v), 32'(tag_clr_valid), 32'(VEC[v][0]));
         if (VEC[v][0]) check($sformatf("R8 vec%0d clr addr", v), 32'(tag_clr_addr), 32'(VEC[v][33:18]));
      end

      // R9: one window of fully useful requests raises the depth.
      do_reset();
      mode = 1'b0;
      for (int i = 0; i < EVAL_T; i++) begin
         do_acc(1'b1, 1'b0, AW'(16'h0800 + i * 4));
         acc_valid = 1'b1; acc_miss = 1'b0; acc_tag = 1'b1; acc_addr = AW'(16'h0801 + i * 4);
         pf_ready = 1'b1;
         @(negedge clk);
         acc_valid = 1'b0; pf_ready = 1'b0;
      end
      check("R9 depth up", 32'(pf_depth), 2);

      // R4 and R5: a two-block lookahead with a stall.
      do_acc(1'b1, 1'b0, 16'h1000);
      check("R4 first", 32'(pf_addr), 32'h1001);
      idle(3);
      check("R5 held valid", 32'(pf_valid), 1);
      check("R5 held addr", 32'(pf_addr), 32'h1001);
      pf_ready = 1'b1;
      @(negedge clk);
      check("R4 second valid", 32'(pf_valid), 1);
      check("R4 second addr", 32'(pf_addr), 32'h1002);
      @(negedge clk);
      check("R4 done", 32'(pf_valid), 0);
      pf_ready = 1'b0;

      // R6: a second miss replaces the pending requests.
      do_acc(1'b1, 1'b0, 16'h2000);
      check("R6 before", 32'(pf_addr), 32'h2001);
      do_acc(1'b1, 1'b0, 16'h3000);
      check("R6 replaced", 32'(pf_addr), 32'h3001);
      pf_ready = 1'b1;
      @(negedge clk);
      check("R6 next", 32'(pf_addr), 32'h3002);
      @(negedge clk);
      check("R6 drained", 32'(pf_valid), 0);

      // R10: twelve more useless requests close the window with no use.
      for (int i = 0; i < 6; i++) begin
         do_acc(1'b1, 1'b0, AW'(16'h4000 + i * 8));
         idle(2);
      end
      check("R10 depth down", 32'(pf_depth), 1);

      // R11 floor: another useless window leaves the depth at 1.
      for (int i = 0; i < EVAL_T; i++) begin
         do_acc(1'b1, 1'b0, AW'(16'h5000 + i * 8));
         idle(1);
      end
      check("R11 floor", 32'(pf_depth), 1);

      // R11 ceiling: useful windows push the depth to KMAX and no further.
      for (int i = 0; i < 70; i++) begin
         pf_ready = 1'b0;
         do_acc(1'b1, 1'b0, AW'(16'h6000 + i * 16));
         pf_ready = 1'b1;
         for (int j = 0; j < KMAX_T; j++) begin
            acc_valid = 1'b1; acc_miss = 1'b0; acc_tag = 1'b1; acc_addr = AW'(16'h6001 + i * 16 + j);
            @(negedge clk);
         end
         acc_valid = 1'b0;
         if (i == 50) check("R11 reach max", 32'(pf_depth), KMAX_T);
      end
      check("R11 ceiling held", 32'(pf_depth), KMAX_T);
      pf_ready = 1'b0;

      // R7: wrap across a multi-block lookahead.
      do_acc(1'b1, 1'b0, 16'hFFFE);
      check("R7 first", 32'(pf_addr), 32'hFFFF);
      pf_ready = 1'b1;
      @(negedge clk);
      check("R7 wrapped", 32'(pf_addr), 32'h0000);
      pf_ready = 1'b0;

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int c = 0; c < 20000; c++) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule